// File: doc/BRIEF.md
# Oversampled Serial Bit Recovery

This block takes an asynchronous single-wire serial line and turns it into a stream of data bits. The line is sampled on a local clock that runs at a fixed integer multiple of the nominal bit rate (`RATIO`, one of 8, 10 or 16). The raw sample first passes through a synchronizer chain. A phase counter then tracks the sample position inside the current bit cell, and each line transition is judged by the slot in which it arrives.

A transition in slot 0 confirms the current alignment. A transition one slot late or one slot early moves the counter by one sample toward the edge. Any other slot is an alignment error: the counter keeps running unchanged and a one-cycle error pulse is raised. At the mid-cell slot the block emits a one-cycle strobe and the bit value, and the next stage uses that strobe as its clock enable.

When no transition is seen for `DEAD_CELLS` whole bit cells, the line is declared dead and strobes stop. The next transition clears the dead state and places the counter so that this transition falls in slot 0.

Top module: `bitcell_recover`

## Requirements
- R1: During and directly after synchronous reset, `valid_o` and `align_err_o` are 0 and `dead_o` is 1.
- R2: The line passes through a two-stage synchronizer. A transition that ends the dead state produces its first strobe `RATIO/2+2` clock edges after the edge that first captures the new level, and `bit_o` then carries that level.
- R3: While the line is not dead, `valid_o` is high for exactly one cycle per `RATIO`-cycle cell, and `bit_o` equals the synchronized line level in mid-cell slot `RATIO/2`.
- R4: A transition in slot 0 leaves the phase untouched, so consecutive strobes stay `RATIO` cycles apart.
- R5: A transition in slot 1 (one late) holds the counter for one cycle, so the strobe gap across it is `RATIO+1`.
- R6: A transition in slot `RATIO-1` (one early) starts the new cell at once, so the strobe gap across it is `RATIO-1`.
- R7: A transition in any other slot while not dead raises `align_err_o` for one cycle and does not change the strobe spacing.
- R8: After `DEAD_CELLS` complete cells without a transition, `dead_o` rises and no strobe is issued while it stays high.
- R9: A transition while dead clears `dead_o` after the same register delay as a strobe decision, re-aligns the phase to slot 0, and raises no error.
- R10: An off-slot transition that lands on the mid-cell slot gives `align_err_o` and `valid_o` in the same cycle, and `bit_o` carries the new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock, `RATIO` times the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Raw asynchronous serial line |
| valid_o | output | 1 | One-cycle strobe per recovered bit |
| bit_o | output | 1 | Recovered data bit, valid with `valid_o` |
| align_err_o | output | 1 | One-cycle pulse for a transition in a non-adjacent slot |
| dead_o | output | 1 | High while the line has shown no transition for `DEAD_CELLS` cells |

## Verification
The alignment-error path and the bit strobe can fire in the same cycle. This happens when a misplaced transition lands exactly on the mid-cell slot. The bench provokes it with a directed cell that is stretched by half a cell. It then requires the error pulse and the strobe to be high together, the strobe spacing to stay at `RATIO`, and the sampled bit to be the level after the transition. Random cells with small and large jitter and occasional long silences exercise the same coincidence against a cycle model written from the requirements.

// File: rtl/bitcell_pkg.sv
`timescale 1ns/1ps
package bitcell_pkg;

   typedef enum logic [1:0] {
      SLOT_ON    = 2'd0,
      SLOT_LATE  = 2'd1,
      SLOT_EARLY = 2'd2,
      SLOT_OFF   = 2'd3
   } slot_e;

   function automatic bit ratio_ok(input int r);
      return (r == 8) || (r == 10) || (r == 16);
   endfunction

endpackage

// File: rtl/bitcell_sync.sv
`timescale 1ns/1ps
module bitcell_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic line_i,
   output logic level_o,
   output logic edge_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("bitcell_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) chain_q[0] <= 1'b0;
            else     chain_q[0] <= line_i;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) chain_q[i] <= 1'b0;
            else     chain_q[i] <= chain_q[i-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) prev_q <= 1'b0;
      else     prev_q <= chain_q[STAGES-1];
   end

   assign level_o = chain_q[STAGES-1];
   assign edge_o  = chain_q[STAGES-1] ^ prev_q;

   // R2: the held previous sample follows the synchronized level one cycle later
   a_r2_prev_follows: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (prev_q == $past(level_o)));

endmodule

// File: rtl/bitcell_phase.sv
`timescale 1ns/1ps
module bitcell_phase
   import bitcell_pkg::*;
#(
   parameter  int RATIO = 8,
   localparam int PW    = $clog2(RATIO)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          edge_i,
   input  logic          dead_i,
   output logic [PW-1:0] ph_o,
   output slot_e         slot_o,
   output logic          wrap_o,
   output logic          mid_o
);

   localparam logic [PW-1:0] LAST = PW'(RATIO - 1);
   localparam logic [PW-1:0] MID  = PW'(RATIO / 2);
   localparam logic [PW-1:0] ONE  = PW'(1);

   logic [PW-1:0] ph_q;
   logic          realign;

   always_comb begin
      if (ph_q == '0)        slot_o = SLOT_ON;
      else if (ph_q == ONE)  slot_o = SLOT_LATE;
      else if (ph_q == LAST) slot_o = SLOT_EARLY;
      else                   slot_o = SLOT_OFF;
   end

   assign realign = edge_i && (dead_i || (slot_o != SLOT_OFF));

   always_ff @(posedge clk) begin
      if (rst)               ph_q <= '0;
      else if (realign)      ph_q <= ONE;
      else if (ph_q == LAST) ph_q <= '0;
      else                   ph_q <= ph_q + 1'b1;
   end

   assign ph_o   = ph_q;
   assign wrap_o = (ph_q == LAST);
   assign mid_o  = (ph_q == MID);

   a_r4_phase_range: assert property (@(posedge clk) disable iff (rst)
      ph_q <= LAST);

   a_r5_late_hold: assert property (@(posedge clk) disable iff (rst)
      (edge_i && !dead_i && ph_q == ONE) |=> (ph_q == ONE));

   a_r6_early_skip: assert property (@(posedge clk) disable iff (rst)
      (edge_i && !dead_i && ph_q == LAST) |=> (ph_q == ONE));

   a_r9_dead_align: assert property (@(posedge clk) disable iff (rst)
      (edge_i && dead_i) |=> (ph_q == ONE));

   a_r7_off_keeps: assert property (@(posedge clk) disable iff (rst)
      (edge_i && !dead_i && ph_q > ONE && ph_q < LAST) |=> (ph_q == $past(ph_q) + 1'b1));

endmodule

// File: rtl/bitcell_idle.sv
`timescale 1ns/1ps
module bitcell_idle #(
   parameter  int CELLS = 16,
   localparam int CW    = $clog2(CELLS + 1)
) (
   input  logic clk,
   input  logic rst,
   input  logic edge_i,
   input  logic wrap_i,
   output logic dead_o
);

   if (CELLS < 2) begin : g_bad_cells
      $error("bitcell_idle: CELLS must be at least 2");
   end

   logic [CW-1:0] quiet_q;
   logic          dead_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         quiet_q <= '0;
         dead_q  <= 1'b1;
      end else if (edge_i) begin
         quiet_q <= '0;
         dead_q  <= 1'b0;
      end else if (wrap_i && !dead_q) begin
         if (quiet_q == CW'(CELLS - 1)) dead_q  <= 1'b1;
         else                           quiet_q <= quiet_q + 1'b1;
      end
   end

   assign dead_o = dead_q;

   a_r9_edge_clears: assert property (@(posedge clk) disable iff (rst)
      edge_i |=> !dead_o);

   a_r8_dead_sticks: assert property (@(posedge clk) disable iff (rst)
      (dead_o && !edge_i) |=> dead_o);

   a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
      quiet_q < CW'(CELLS));

endmodule

// File: rtl/bitcell_recover.sv
`timescale 1ns/1ps
module bitcell_recover
   import bitcell_pkg::*;
#(
   parameter int RATIO       = 8,
   parameter int DEAD_CELLS  = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic line_i,
   output logic valid_o,
   output logic bit_o,
   output logic align_err_o,
   output logic dead_o
);

   localparam int PW = $clog2(RATIO);

   if (!ratio_ok(RATIO)) begin : g_bad_ratio
      $error("bitcell_recover: RATIO must be 8, 10 or 16");
   end

   logic          lvl;
   logic          edg;
   logic [PW-1:0] ph;
   slot_e         slot;
   logic          wrap;
   logic          mid;
   logic          dead;
   logic          valid_q;
   logic          bit_q;
   logic          err_q;

   bitcell_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .line_i  (line_i),
      .level_o (lvl),
      .edge_o  (edg)
   );

   bitcell_phase #(.RATIO(RATIO)) u_phase (
      .clk    (clk),
      .rst    (rst),
      .edge_i (edg),
      .dead_i (dead),
      .ph_o   (ph),
      .slot_o (slot),
      .wrap_o (wrap),
      .mid_o  (mid)
   );

   bitcell_idle #(.CELLS(DEAD_CELLS)) u_idle (
      .clk    (clk),
      .rst    (rst),
      .edge_i (edg),
      .wrap_i (wrap),
      .dead_o (dead)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q <= 1'b0;
         bit_q   <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         valid_q <= mid && !dead;
         if (mid && !dead) bit_q <= lvl;
         err_q   <= edg && !dead && (slot == SLOT_OFF);
      end
   end

   assign valid_o     = valid_q;
   assign bit_o       = bit_q;
   assign align_err_o = err_q;
   assign dead_o      = dead;

   a_r3_strobe_gap: assert property (@(posedge clk) disable iff (rst)
      valid_o |=> !valid_o);

   a_r8_no_strobe_dead: assert property (@(posedge clk) disable iff (rst)
      dead_o |=> !valid_o);

   a_r9_no_err_dead: assert property (@(posedge clk) disable iff (rst)
      dead_o |=> !align_err_o);

   a_r3_bit_stable: assert property (@(posedge clk) disable iff (rst)
      !valid_o |-> $stable(bit_o));

   a_r7_err_needs_phase: assert property (@(posedge clk) disable iff (rst)
      (ph == '0) |=> !align_err_o);

endmodule

// File: tb/bitcell_recover_bench.sv
`timescale 1ns/1ps
module bitcell_recover_bench;

   localparam int OSR  = 8;
   localparam int DEAD = 16;
   localparam int MID  = OSR / 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic line_i = 1'b0;
   logic valid_o, bit_o, align_err_o, dead_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   bit mchk   = 1'b0;

   always #2 clk = ~clk;

   bitcell_recover #(.RATIO(OSR), .DEAD_CELLS(DEAD), .SYNC_STAGES(2)) u_bitcell_recover (
      .clk         (clk),
      .rst         (rst),
      .line_i      (line_i),
      .valid_o     (valid_o),
      .bit_o       (bit_o),
      .align_err_o (align_err_o),
      .dead_o      (dead_o)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Cycle model built from the requirements
   logic m_s1, m_s2, m_prev, m_dead, m_valid, m_bit, m_err;
   int   m_ph, m_quiet;

   always @(posedge clk) begin
      logic e;
      logic near;
      if (rst) begin
         m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_dead <= 1;
         m_valid <= 0; m_bit <= 0; m_err <= 0; m_ph <= 0; m_quiet <= 0;
      end else begin
         e    = (m_s2 != m_prev);
         near = (m_ph == 0) || (m_ph == 1) || (m_ph == OSR - 1);
         m_s1   <= line_i;
         m_s2   <= m_s1;
         m_prev <= m_s2;
         m_valid <= (m_ph == MID) && !m_dead;
         if ((m_ph == MID) && !m_dead) m_bit <= m_s2;
         m_err <= e && !m_dead && !near;
         if (e && (m_dead || near)) m_ph <= 1;
         else m_ph <= (m_ph == OSR - 1) ? 0 : m_ph + 1;
         if (e) begin
            m_quiet <= 0; m_dead <= 0;
         end else if (m_ph == OSR - 1 && !m_dead) begin
            if (m_quiet == DEAD - 1) m_dead <= 1;
            else m_quiet <= m_quiet + 1;
         end
      end
   end

   always @(negedge clk) begin
      if (mchk && !rst) begin
         if (valid_o !== m_valid) chk(0, "R3 strobe vs model", valid_o, m_valid);
         else checks++;
         if (m_valid && bit_o !== m_bit) chk(0, "R3 bit vs model", bit_o, m_bit);
         if (align_err_o !== m_err) chk(0, "R7 error vs model", align_err_o, m_err);
         else checks++;
         if (dead_o !== m_dead) chk(0, "R8 dead vs model", dead_o, m_dead);
         else checks++;
      end
   end

   task automatic send(input logic lvl, input int len);
      line_i = lvl;
      repeat (len) @(negedge clk);
   endtask

   task automatic go_dead();
      line_i = 1'b0;
      repeat (OSR * (DEAD + 3)) @(negedge clk);
   endtask

   task automatic run_case(input int len_b, input int len_c, input int gap,
                           input int exp_err, input bit both, input string tag);
      int ns = 0, t2 = 0, t3 = 0, errs = 0;
      logic b3 = 0, e3 = 0;
      go_dead();
      fork
         begin send(1, OSR); send(0, len_b); send(1, len_c); send(0, OSR); end
         begin
            for (int k = 1; k <= 6 * OSR; k++) begin
               @(negedge clk);
               if (align_err_o) errs++;
               if (valid_o) begin
                  ns++;
                  if (ns == 2) t2 = k;
                  if (ns == 3) begin t3 = k; b3 = bit_o; e3 = align_err_o; end
               end
            end
         end
      join
      chk(t3 - t2 == gap, {tag, " strobe gap"}, t3 - t2, gap);
      chk(errs == exp_err, {tag, " error pulses"}, errs, exp_err);
      if (both) begin
         chk(e3 == 1'b1, "R10 error with strobe", e3, 1);
         chk(b3 == 1'b1, "R10 bit after edge", b3, 1);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] pat;
      int got;
      int tfirst;
      int tprev;
      int dead_k;
      void'($urandom(32'd2024));
      repeat (4) @(negedge clk);
      chk(valid_o == 0, "R1 reset strobe", valid_o, 0);
      chk(align_err_o == 0, "R1 reset error", align_err_o, 0);
      chk(dead_o == 1, "R1 reset dead", dead_o, 1);
      rst = 1'b0;
      @(negedge clk);
      chk(dead_o == 1 && valid_o == 0, "R1 after reset", dead_o, 1);
      mchk = 1'b1;

      // R2 R3 R4 R9: clean stream from the dead state
      pat = 8'b0100_1101;
      got = 0; tfirst = 0; tprev = 0;
      fork
         begin
            for (int i = 0; i < 8; i++) send(pat[i], OSR);
         end
         begin
            for (int k = 1; k <= 8 * OSR; k++) begin
               @(negedge clk);
               if (k == 2) chk(dead_o == 1, "R9 dead before clear", dead_o, 1);
               if (k == 3) chk(dead_o == 0, "R9 dead cleared", dead_o, 0);
               if (align_err_o) chk(0, "R9 no error on realign", 1, 0);
               if (valid_o && got < 8) begin
                  if (got == 0) begin
                     tfirst = k;
                     chk(k == MID + 3, "R2 first strobe latency", k, MID + 3);
                  end else begin
                     chk(k - tprev == OSR, "R4 on-slot gap", k - tprev, OSR);
                  end
                  chk(bit_o == pat[got], "R3 recovered bit", bit_o, pat[got]);
                  tprev = k;
                  got++;
               end
            end
         end
      join
      chk(got == 8, "R3 strobe count", got, 8);

      run_case(OSR + 1, OSR, OSR + 1, 0, 0, "R5 late edge");
      run_case(OSR - 1, OSR, OSR - 1, 0, 0, "R6 early edge");
      run_case(OSR + 3, OSR - 3, OSR, 1, 0, "R7 off-slot edge");
      run_case(OSR + MID, OSR - MID, OSR, 1, 1, "R10 mid-slot edge");

      // R8: dead after DEAD_CELLS cells without transition
      go_dead();
      dead_k = 0;
      line_i = 1'b1;
      for (int k = 1; k <= OSR * DEAD + 4 * OSR; k++) begin
         @(negedge clk);
         if (k == OSR * DEAD + 1) chk(dead_o == 0, "R8 not yet dead", dead_o, 0);
         if (k == OSR * DEAD + 2) chk(dead_o == 1, "R8 dead onset", dead_o, 1);
         if (k > OSR * DEAD + 2 && valid_o) chk(0, "R8 strobe while dead", 1, 0);
      end

      // Random cells with jitter, glitches and silences
      for (int c = 0; c < 2500; c++) begin
         int r;
         int len;
         r = $urandom % 100;
         if (r < 70) len = OSR;
         else if (r < 80) len = OSR + 1;
         else if (r < 90) len = OSR - 1;
         else if (r < 98) len = 2 + ($urandom % (2 * OSR - 3));
         else len = OSR * (DEAD + 2);
         send(logic'($urandom % 2), len);
      end
      repeat (4) @(negedge clk);

      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule